// File: doc/BRIEF.md
# Interrupt destination mask generator

This block decides which processor-local interrupt controllers in a small cluster take an interrupt message. It reads the message's addressing fields: an 8-bit destination, a physical/logical mode bit, a 2-bit shorthand code and the sender's index. It also reads a snapshot of each agent's identity registers, and from all of these it forms an N-bit target mask with one bit per agent. A second N-bit output carries a single target, the lowest-indexed agent in that mask, for messages that use lowest-priority delivery.

A requester pulses `req_valid` with the addressing fields stable. One clock later `tgt_valid` pulses and the registered masks show the result. The masks keep that value until the next strobe. Each agent supplies three things: its 8-bit ID, its logical-destination register image (the logical ID sits in bits 31:24) and its destination-format register image (the model field sits in bits 31:28). Arbitration between agents and the transport of the message are handled elsewhere.

Top module: `irq_dest_mask`

## Requirements
- R1: While reset is asserted and after its release, `tgt_valid`, `tgt_mask` and `tgt_lowest` are all zero until the first strobe.
- R2: `tgt_valid` is high exactly in the cycle after a cycle with `req_valid` high, and carries the result of that request. Without a strobe, `tgt_mask` and `tgt_lowest` hold their values.
- R3: Shorthand code 1 (self) selects only the agent numbered `req_sender`.
- R4: Shorthand code 2 (all) selects every agent.
- R5: Shorthand code 3 (others) selects every agent except the agent numbered `req_sender`.
- R6: Shorthand code 0 with `req_logical`=0 and destination 8'hFF selects every agent.
- R7: Shorthand code 0 with `req_logical`=0 and any other destination selects the agent whose ID equals the destination. If several agents share that ID, only the lowest-indexed one is selected. If no ID matches, no agent is selected.
- R8: Shorthand code 0 with `req_logical`=1 selects a flat-model agent (model field 4'hF) when the destination ANDed with its logical ID is nonzero.
- R9: Shorthand code 0 with `req_logical`=1 selects a cluster-model agent (model field 4'h0) when the upper nibbles of the destination and its logical ID are equal and their lower nibbles share a set bit.
- R10: In logical mode an agent whose model field is neither 4'h0 nor 4'hF is never selected.
- R11: `tgt_lowest` has only the lowest-indexed set bit of `tgt_mask` set, and is zero when `tgt_mask` is zero.
- R12: The logical ID is taken only from bits 31:24 of the logical-destination image and the model only from bits 31:28 of the format image. The other bits of those images have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per message |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| req_shorthand | input | 2 | 0 dest field, 1 self, 2 all, 3 all but self |
| req_sender | input | IDX_W | Index of the sending agent |
| agent_id_flat | input | N_AGENTS*8 | Agent IDs, agent i at bits [8i+7:8i] |
| agent_ldr_flat | input | N_AGENTS*32 | Logical-destination register images, agent i at [32i+31:32i] |
| agent_dfr_flat | input | N_AGENTS*32 | Destination-format register images, agent i at [32i+31:32i] |
| tgt_valid | output | 1 | Result valid, one cycle after the strobe |
| tgt_mask | output | N_AGENTS | Registered delivery mask |
| tgt_lowest | output | N_AGENTS | Registered single-target mask for lowest-priority delivery |

## Verification
Two functions always resolve in the same cycle: the full mask and the lowest-priority pick, which is taken from that mask. The hardest case for them is an all-but-self request from agent 0, where the pick must move to agent 1. It is provoked together with physical requests in which several agents share the addressed ID, so that the duplicate-ID pick and the lowest-priority pick both act on one message. A scoreboard model predicts both masks for each strobe from the requirements and compares them in the cycle `tgt_valid` rises. Directed cases are followed by back-to-back random requests over random agent configurations.

// File: rtl/dmg_pkg.sv
package dmg_pkg;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam int DEST_W    = 8;
  localparam int REG_W     = 32;
  localparam int LID_MSB   = 31;
  localparam int LID_LSB   = 24;
  localparam int MODEL_MSB = 31;
  localparam int MODEL_LSB = 28;
  localparam int MODEL_W   = MODEL_MSB - MODEL_LSB + 1;

  localparam logic [DEST_W-1:0]  DEST_BCAST    = '1;
  localparam logic [MODEL_W-1:0] MODEL_FLAT    = '1;
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = '0;

endpackage

// File: rtl/dmg_agent_match.sv
module dmg_agent_match
  import dmg_pkg::*;
(
  input  logic [DEST_W-1:0] dest,
  input  logic [DEST_W-1:0] agent_id,
  input  logic [REG_W-1:0]  ldr_reg,
  input  logic [REG_W-1:0]  dfr_reg,
  output logic              phys_hit,
  output logic              log_hit
);

  localparam int HALF_W = DEST_W / 2;

  logic [DEST_W-1:0]  lid;
  logic [MODEL_W-1:0] model;
  logic               flat_hit;
  logic               clus_hit;
  logic               unused_fields;

  assign lid   = ldr_reg[LID_MSB:LID_LSB];
  assign model = dfr_reg[MODEL_MSB:MODEL_LSB];
  assign unused_fields = ^{ldr_reg[LID_LSB-1:0], dfr_reg[MODEL_LSB-1:0]};

  always_comb begin
    phys_hit = (agent_id == dest);
    flat_hit = |(dest & lid);
    clus_hit = (dest[DEST_W-1:HALF_W] == lid[DEST_W-1:HALF_W]) &&
               (|(dest[HALF_W-1:0] & lid[HALF_W-1:0]));
    unique case (model)
      MODEL_FLAT:    log_hit = flat_hit;
      MODEL_CLUSTER: log_hit = clus_hit;
      default:       log_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/dmg_lowest_pick.sv
module dmg_lowest_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] vec_in,
  output logic [N-1:0] vec_out
);

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  always_comb begin
    vec_out = vec_in & (~vec_in + ONE);
  end

endmodule

// File: rtl/dmg_mask_reg.sv
module dmg_mask_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] d_mask,
  input  logic [N-1:0] d_low,
  output logic [N-1:0] q_mask,
  output logic [N-1:0] q_low,
  output logic         q_vld
);

  logic [N-1:0] mask_nxt;
  logic [N-1:0] low_nxt;
  logic         vld_nxt;

  always_comb begin
    mask_nxt = q_mask;
    low_nxt  = q_low;
    vld_nxt  = load;
    if (load) begin
      mask_nxt = d_mask;
      low_nxt  = d_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_mask <= '0;
      q_low  <= '0;
      q_vld  <= 1'b0;
    end else begin
      q_mask <= mask_nxt;
      q_low  <= low_nxt;
      q_vld  <= vld_nxt;
    end
  end

endmodule

// File: rtl/irq_dest_mask.sv
module irq_dest_mask
  import dmg_pkg::*;
#(
  parameter int N_AGENTS = 8,
  parameter int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [DEST_W-1:0]           req_dest,
  input  logic                        req_logical,
  input  logic [1:0]                  req_shorthand,
  input  logic [IDX_W-1:0]            req_sender,
  input  logic [N_AGENTS*DEST_W-1:0]  agent_id_flat,
  input  logic [N_AGENTS*REG_W-1:0]   agent_ldr_flat,
  input  logic [N_AGENTS*REG_W-1:0]   agent_dfr_flat,
  output logic                        tgt_valid,
  output logic [N_AGENTS-1:0]         tgt_mask,
  output logic [N_AGENTS-1:0]         tgt_lowest
);

  localparam logic [N_AGENTS-1:0] ALL_ONES = '1;

  logic [N_AGENTS-1:0] phys_hit;
  logic [N_AGENTS-1:0] log_hit;
  logic [N_AGENTS-1:0] phys_first;
  logic [N_AGENTS-1:0] sender_oh;
  logic [N_AGENTS-1:0] dest_mask;
  logic [N_AGENTS-1:0] mask_nxt;
  logic [N_AGENTS-1:0] low_nxt;
  shorthand_e          sh;

  // Per-agent address comparison
  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    dmg_agent_match u_match (
      .dest     (req_dest),
      .agent_id (agent_id_flat[g*DEST_W +: DEST_W]),
      .ldr_reg  (agent_ldr_flat[g*REG_W +: REG_W]),
      .dfr_reg  (agent_dfr_flat[g*REG_W +: REG_W]),
      .phys_hit (phys_hit[g]),
      .log_hit  (log_hit[g])
    );
    assign sender_oh[g] = (req_sender == IDX_W'(g));
  end

  // Duplicate physical IDs resolve to the lowest index
  dmg_lowest_pick #(.N(N_AGENTS)) u_phys_pick (
    .vec_in  (phys_hit),
    .vec_out (phys_first)
  );

  always_comb begin
    sh = shorthand_e'(req_shorthand);
    if (req_logical) begin
      dest_mask = log_hit;
    end else if (req_dest == DEST_BCAST) begin
      dest_mask = ALL_ONES;
    end else begin
      dest_mask = phys_first;
    end
    unique case (sh)
      SH_SELF:   mask_nxt = sender_oh;
      SH_ALL:    mask_nxt = ALL_ONES;
      SH_OTHERS: mask_nxt = ~sender_oh;
      default:   mask_nxt = dest_mask;
    endcase
  end

  // Single target for lowest-priority delivery
  dmg_lowest_pick #(.N(N_AGENTS)) u_lp_pick (
    .vec_in  (mask_nxt),
    .vec_out (low_nxt)
  );

  dmg_mask_reg #(.N(N_AGENTS)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (req_valid),
    .d_mask (mask_nxt),
    .d_low  (low_nxt),
    .q_mask (tgt_mask),
    .q_low  (tgt_lowest),
    .q_vld  (tgt_valid)
  );

  // R2: result strobe follows request strobe by one cycle
  p_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> tgt_valid);
  p_novld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !tgt_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(tgt_mask) && $stable(tgt_lowest)));

  // R3 / R4 / R5: shorthand overrides
  p_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_shorthand == 2'd1) |=>
      (tgt_mask == (N_AGENTS'(1) << $past(req_sender))));
  p_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_shorthand == 2'd2) |=> (tgt_mask == ALL_ONES));
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_shorthand == 2'd3) |=>
      (!tgt_mask[$past(req_sender)] && $countones(tgt_mask) == N_AGENTS - 1));

  // R6 / R7: physical addressing
  p_bcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_shorthand == 2'd0 && !req_logical && req_dest == DEST_BCAST)
      |=> (tgt_mask == ALL_ONES));
  p_phys_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_shorthand == 2'd0 && !req_logical && req_dest != DEST_BCAST)
      |=> ($countones(tgt_mask) <= 1));

  // R11: single target is one bit of the mask
  p_low_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_lowest));
  p_low_subset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt_lowest & ~tgt_mask) == '0));
  p_low_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_mask != '0) |-> (tgt_lowest != '0));

endmodule

// File: tb/irq_dest_mask_tb_top.sv
`timescale 1ns/1ps
module irq_dest_mask_tb_top;

  localparam int N  = 8;
  localparam int IW = 3;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [7:0]        req_dest;
  logic              req_logical;
  logic [1:0]        req_shorthand;
  logic [IW-1:0]     req_sender;
  logic [N*8-1:0]    agent_id_flat;
  logic [N*32-1:0]   agent_ldr_flat;
  logic [N*32-1:0]   agent_dfr_flat;
  logic              tgt_valid;
  logic [N-1:0]      tgt_mask;
  logic [N-1:0]      tgt_lowest;

  logic [7:0]  ids [N];
  logic [31:0] ldr [N];
  logic [31:0] dfr [N];

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] last_mask;
  logic [N-1:0] last_low;

  logic [N-1:0] exp_mask_q [$];
  logic [N-1:0] exp_low_q  [$];
  string        tag_q      [$];

  irq_dest_mask #(.N_AGENTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
    .req_logical(req_logical), .req_shorthand(req_shorthand),
    .req_sender(req_sender), .agent_id_flat(agent_id_flat),
    .agent_ldr_flat(agent_ldr_flat), .agent_dfr_flat(agent_dfr_flat),
    .tgt_valid(tgt_valid), .tgt_mask(tgt_mask), .tgt_lowest(tgt_lowest)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      agent_id_flat[i*8 +: 8]   = ids[i];
      agent_ldr_flat[i*32 +: 32] = ldr[i];
      agent_dfr_flat[i*32 +: 32] = dfr[i];
    end
  end

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_mask(input logic [7:0] d, input logic lg,
                                              input logic [1:0] sh, input logic [IW-1:0] snd);
    logic [N-1:0] m;
    logic [7:0] lid;
    logic [3:0] mdl;
    m = '0;
    case (sh)
      2'd1: m[snd] = 1'b1;
      2'd2: m = '1;
      2'd3: begin m = '1; m[snd] = 1'b0; end
      default: begin
        if (!lg) begin
          if (d == 8'hFF) m = '1;
          else begin
            for (int i = N - 1; i >= 0; i--) if (ids[i] == d) m = N'(1) << i;
          end
        end else begin
          for (int i = 0; i < N; i++) begin
            lid = ldr[i][31:24];
            mdl = dfr[i][31:28];
            if (mdl == 4'hF) m[i] = (d & lid) != 8'h00;
            else if (mdl == 4'h0)
              m[i] = (d[7:4] == lid[7:4]) && ((d[3:0] & lid[3:0]) != 4'h0);
          end
        end
      end
    endcase
    return m;
  endfunction

  function automatic logic [N-1:0] model_low(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return N'(1) << i;
    return '0;
  endfunction

  task automatic send(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                      input logic [IW-1:0] snd, input string tag);
    logic [N-1:0] em;
    @(negedge clk);
    req_dest = d; req_logical = lg; req_shorthand = sh; req_sender = snd;
    req_valid = 1'b1;
    em = model_mask(d, lg, sh, snd);
    exp_mask_q.push_back(em);
    exp_low_q.push_back(model_low(em));
    tag_q.push_back(tag);
    last_mask = em;
    last_low  = model_low(em);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (rst_n && tgt_valid) begin
      if (exp_mask_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 actual=unexpected result expected=none");
      end else begin
        string t;
        logic [N-1:0] em, el;
        t  = tag_q.pop_front();
        em = exp_mask_q.pop_front();
        el = exp_low_q.pop_front();
        check(t, tgt_mask, em);
        check({t, " R11"}, tgt_lowest, el);
      end
    end
  end

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  task automatic set_agent(input int i, input logic [7:0] id, input logic [31:0] l, input logic [31:0] f);
    ids[i] = id; ldr[i] = l; dfr[i] = f;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_dest = '0; req_logical = 1'b0;
    req_shorthand = '0; req_sender = '0;
    for (int i = 0; i < N; i++) set_agent(i, 8'(i), 32'h0, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    check("R1 valid", {{(N-1){1'b0}}, tgt_valid}, '0);
    check("R1 mask", tgt_mask, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 low after release", tgt_lowest, '0);
    check("R1 mask after release", tgt_mask, '0);

    // Shorthands
    send(8'h05, 1'b0, 2'd1, 3'd3, "R3 self");
    send(8'h05, 1'b1, 2'd2, 3'd6, "R4 all");
    send(8'h01, 1'b0, 2'd3, 3'd0, "R5 others sender0");
    send(8'h01, 1'b0, 2'd3, 3'd7, "R5 others sender7");
    idle(3);
    checks++;
    if (tgt_valid !== 1'b0 || tgt_mask !== last_mask || tgt_lowest !== last_low) begin
      fails++;
      $display("FAIL R2 hold actual=%b/%b/%b expected=0/%b/%b",
               tgt_valid, tgt_mask, tgt_lowest, last_mask, last_low);
    end

    // Physical
    send(8'hFF, 1'b0, 2'd0, 3'd2, "R6 broadcast");
    send(8'h04, 1'b0, 2'd0, 3'd2, "R7 unique id");
    set_agent(2, 8'h33, 32'h0, 32'hFFFF_FFFF);
    set_agent(5, 8'h33, 32'h0, 32'hFFFF_FFFF);
    set_agent(6, 8'h33, 32'h0, 32'hFFFF_FFFF);
    send(8'h33, 1'b0, 2'd0, 3'd2, "R7 duplicate id");
    send(8'h99, 1'b0, 2'd0, 3'd2, "R7 no match");
    idle(1);

    // Logical flat / cluster / other models
    set_agent(0, 8'h00, 32'h0100_0000, 32'hF000_0000);
    set_agent(1, 8'h01, 32'h0200_0000, 32'hF000_0000);
    set_agent(2, 8'h02, 32'h8400_0000, 32'hF000_0000);
    set_agent(3, 8'h03, 32'h3100_0000, 32'h0000_0000);
    set_agent(4, 8'h04, 32'h3600_0000, 32'h0000_0000);
    set_agent(5, 8'h05, 32'h4100_0000, 32'h0000_0000);
    set_agent(6, 8'h06, 32'hFF00_0000, 32'h5000_0000);
    set_agent(7, 8'h07, 32'hFF00_0000, 32'h7000_0000);
    send(8'h06, 1'b1, 2'd0, 3'd0, "R8 flat");
    send(8'h80, 1'b1, 2'd0, 3'd0, "R8 flat single");
    send(8'h32, 1'b1, 2'd0, 3'd0, "R9 cluster");
    send(8'h43, 1'b1, 2'd0, 3'd0, "R9 cluster other group");
    send(8'h38, 1'b1, 2'd0, 3'd0, "R9 cluster no low overlap");
    send(8'h00, 1'b1, 2'd0, 3'd0, "R11 empty");
    idle(1);
    for (int i = 0; i < N; i++) set_agent(i, 8'hFF, 32'hFF00_0000, 32'h3FFF_FFFF);
    send(8'hFF, 1'b1, 2'd0, 3'd0, "R10 other model");
    // Noise outside the fields: flat agent with zero logical ID, cluster via low bits only
    set_agent(0, 8'h00, 32'h00FF_FFFF, 32'hF0FF_FFFF);
    set_agent(1, 8'h00, 32'h21FF_FFFF, 32'h0FFF_FFFF);
    send(8'h21, 1'b1, 2'd0, 3'd0, "R12 outside bits");
    idle(1);

    // Random back-to-back
    for (int k = 0; k < 300; k++) begin
      for (int i = 0; i < N; i++) begin
        logic [3:0] mdl;
        case ($urandom_range(0, 2))
          0: mdl = 4'h0;
          1: mdl = 4'hF;
          default: mdl = 4'($urandom);
        endcase
        set_agent(i, 8'($urandom_range(0, 7)), $urandom, {mdl, 28'($urandom)});
      end
      send(($urandom_range(0, 5) == 0) ? 8'hFF : 8'($urandom_range(0, 9)) | (8'($urandom) & 8'hF0 & {8{k[0]}}),
           1'($urandom), 2'($urandom), IW'($urandom), "random");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(3);
    checks++;
    if (exp_mask_q.size() != 0) begin
      fails++;
      $display("FAIL R2 actual=%0d pending expected=0", exp_mask_q.size());
    end
    report();
    $finish;
  end

endmodule